// File: doc/BRIEF.md
# Memory-Mapped ISA I/O Window Translator

This block sits between a big-endian CPU bus and a little-endian ISA-style I/O bus. A CPU access whose address falls inside an 8 MB window starting at 0x80000000 is turned into an I/O port access. The port address is built from the CPU address by one of two compaction maps. The map is chosen by a mode input that comes from a system control register. In the flat map the port is simply the low 16 address bits. In the split map the low five address bits stay in place and a field taken from the 4 KB page number fills the upper port bits. As a result each group of 32 ports sits in its own 4 KB page.

Halfword and word data are byte-swapped in both directions, so the CPU sees I/O registers in its own byte order. Byte data passes through unchanged. A fixed 4-byte location at 0xBFFFFFF0 acts as an interrupt-acknowledge port. A read of its first byte returns the vector from the interrupt controller, swapped by access size, and pulses an acknowledge strobe toward that controller.

A request is accepted only when no read is outstanding. Outputs are registered one cycle after acceptance. A forwarded read finishes in the cycle after the I/O side signals valid data. Every other access finishes one cycle after acceptance.

Top module: `isa_window_xlate`

## Requirements
- R1: After reset, ioRd, ioWr, iackStb and cpuDone are low and cpuRdata is zero.
- R2: An access accepted with cpuAddr in 0x80000000..0x807FFFFF raises exactly one one-cycle strobe in the next cycle: ioWr when cpuWe=1, ioRd when cpuWe=0. ioSize equals cpuSize in that cycle.
- R3: With mapSplit=0, ioPort equals cpuAddr[15:0], zero-extended to 20 bits.
- R4: With mapSplit=1, ioPort[4:0] equals cpuAddr[4:0] and ioPort[19:5] equals cpuAddr[26:12].
- R5: Write data is laned by cpuSize, where 0 is byte, 1 is halfword and 2 (or 3) is word. For a byte, ioWdata equals cpuWdata. For a halfword, ioWdata is {16'h0, cpuWdata[7:0], cpuWdata[15:8]}. For a word, ioWdata is cpuWdata with its four bytes reversed. A forwarded write pulses cpuDone in the same cycle as ioWr.
- R6: For a forwarded read, cpuDone pulses in the cycle after ioRvalid. cpuRdata then holds ioRdata swapped by the rule in R5, using the size of the access.
- R7: A read of 0xBFFFFFF0 pulses iackStb and cpuDone in the next cycle. cpuRdata is then the swapped zero-extended iackVec: the vector itself for a byte, vector<<8 for a halfword, vector<<24 for a word.
- R8: Reads of 0xBFFFFFF1..0xBFFFFFF3 return zero. Writes anywhere in 0xBFFFFFF0..0xBFFFFFF3 raise no strobe at all and only pulse cpuDone.
- R9: An access outside both regions raises no I/O or acknowledge strobe, pulses cpuDone in the next cycle and reads as zero.
- R10: mapSplit is sampled when an access is accepted. ioPort keeps its value until the next accepted access, even if mapSplit changes in between.
- R11: A cpuReq that arrives while a forwarded read awaits ioRvalid is ignored: it produces no strobe and no extra cpuDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mapSplit | input | 1 | Address map select: 0 flat, 1 split |
| cpuReq | input | 1 | One-cycle access request |
| cpuWe | input | 1 | 1 write, 0 read |
| cpuAddr | input | 32 | CPU byte address |
| cpuSize | input | 2 | 0 byte, 1 halfword, 2/3 word |
| cpuWdata | input | 32 | CPU write data, right-justified |
| cpuRdata | output | 32 | Read data to CPU |
| cpuDone | output | 1 | Access completion pulse |
| ioRd | output | 1 | I/O read strobe |
| ioWr | output | 1 | I/O write strobe |
| ioPort | output | 20 | I/O port address |
| ioSize | output | 2 | I/O access size |
| ioWdata | output | 32 | Swapped I/O write data |
| ioRdata | input | 32 | I/O read data |
| ioRvalid | input | 1 | I/O read data valid |
| iackVec | input | 8 | Interrupt vector from the interrupt controller |
| iackStb | output | 1 | Interrupt-acknowledge pulse |

## Verification
The hardest case to reach is a change of map mode, or a new request, that lands while a forwarded read is still waiting for its data. Only a slow I/O responder leaves that window open. The bench therefore models the device with a random response delay. In directed cases it flips mapSplit and fires an extra window write during that delay, then checks that the port address and strobes stay untouched. Random traffic spreads accesses over the window, the acknowledge location and its neighbours, and unmapped space, with all three sizes and both modes.

// File: rtl/isa_xlate_pkg.sv
package isa_xlate_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  // Decode result handed from the datapath to the control.
  typedef struct packed {
    logic hitWin;
    logic hitIack;
    logic hitIackVec;
  } decode_t;

  // Strobes from the control into the datapath registers.
  typedef struct packed {
    logic loadIo;
    logic loadLocal;
    logic capRead;
  } ctrlStb_t;

  // Byte lane swap between big-endian CPU and little-endian I/O bus.
  function automatic logic [31:0] laneSwap(input logic [31:0] d, input logic [1:0] sz);
    logic [31:0] r;
    r = d;
    if (sz == SZ_HALF) begin
      r = {16'h0000, d[7:0], d[15:8]};
    end else if (sz != SZ_BYTE) begin
      for (int i = 0; i < 4; i++) begin
        r[8*i +: 8] = d[8*(3-i) +: 8];
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/isa_xlate_ctrl.sv
module isa_xlate_ctrl
  import isa_xlate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cpuReq,
  input  logic     cpuWe,
  input  decode_t  dec,
  input  logic     ioRvalid,
  output ctrlStb_t stb,
  output logic     ioRd,
  output logic     ioWr,
  output logic     iackStb,
  output logic     cpuDone
);

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } state_e;

  state_e state;
  logic   accept;
  logic   fwdRead;
  logic   fwdWrite;
  logic   readBack;

  assign accept   = cpuReq && (state == ST_IDLE);
  assign fwdRead  = accept && dec.hitWin && !cpuWe;
  assign fwdWrite = accept && dec.hitWin && cpuWe;
  assign readBack = (state == ST_WAIT) && ioRvalid;

  always_comb begin
    stb.loadIo    = accept && dec.hitWin;
    stb.loadLocal = accept && !dec.hitWin;
    stb.capRead   = readBack;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ioRd    <= 1'b0;
      ioWr    <= 1'b0;
      iackStb <= 1'b0;
      cpuDone <= 1'b0;
    end else begin
      ioRd    <= fwdRead;
      ioWr    <= fwdWrite;
      iackStb <= accept && dec.hitIackVec && !cpuWe;
      cpuDone <= (accept && !fwdRead) || readBack;
      case (state)
        ST_IDLE: if (fwdRead) state <= ST_WAIT;
        ST_WAIT: if (ioRvalid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/isa_xlate_dp.sv
module isa_xlate_dp
  import isa_xlate_pkg::*;
#(
  parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
  parameter int          WIN_LOG2   = 23,
  parameter logic [31:0] IACK_ADDR  = 32'hBFFF_FFF0,
  parameter int          PORT_W     = 20,
  parameter int          FLAT_W     = 16,
  parameter int          LOW_BITS   = 5,
  parameter int          PAGE_LOG2  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mapSplit,
  input  logic              cpuWe,
  input  logic [31:0]       cpuAddr,
  input  logic [1:0]        cpuSize,
  input  logic [31:0]       cpuWdata,
  input  logic [31:0]       ioRdata,
  input  logic [7:0]        iackVec,
  input  ctrlStb_t          stb,
  output decode_t           dec,
  output logic [PORT_W-1:0] ioPort,
  output logic [1:0]        ioSize,
  output logic [31:0]       ioWdata,
  output logic [31:0]       cpuRdata
);

  localparam int HIGH_BITS = PORT_W - LOW_BITS;
  localparam int WIN_TAG_W = 32 - WIN_LOG2;

  logic [PORT_W-1:0] flatPort;
  logic [PORT_W-1:0] splitPort;
  logic [PORT_W-1:0] nextPort;
  logic [31:0]       localData;
  logic [1:0]        heldSize;

  always_comb begin
    dec.hitWin     = cpuAddr[31:WIN_LOG2] == WIN_BASE[31:WIN_LOG2];
    dec.hitIack    = cpuAddr[31:2] == IACK_ADDR[31:2];
    dec.hitIackVec = cpuAddr == IACK_ADDR;
  end

  generate
    if (PORT_W > FLAT_W) begin : g_flatPad
      assign flatPort = {{(PORT_W-FLAT_W){1'b0}}, cpuAddr[FLAT_W-1:0]};
    end else begin : g_flatCut
      assign flatPort = cpuAddr[PORT_W-1:0];
    end
  endgenerate

  assign splitPort = {cpuAddr[PAGE_LOG2 +: HIGH_BITS], cpuAddr[LOW_BITS-1:0]};
  assign nextPort  = mapSplit ? splitPort : flatPort;
  assign localData = (dec.hitIackVec && !cpuWe) ? laneSwap({24'h0, iackVec}, cpuSize) : 32'h0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioPort   <= '0;
      ioSize   <= 2'd0;
      heldSize <= 2'd0;
      ioWdata  <= 32'h0;
      cpuRdata <= 32'h0;
    end else begin
      if (stb.loadIo) begin
        ioPort   <= nextPort;
        ioSize   <= cpuSize;
        heldSize <= cpuSize;
        ioWdata  <= laneSwap(cpuWdata, cpuSize);
      end
      if (stb.loadLocal) begin
        cpuRdata <= localData;
      end else if (stb.capRead) begin
        cpuRdata <= laneSwap(ioRdata, heldSize);
      end
    end
  end

  logic unusedTag;
  assign unusedTag = ^WIN_TAG_W;

endmodule

// File: rtl/isa_window_xlate.sv
module isa_window_xlate
  import isa_xlate_pkg::*;
#(
  parameter int PORT_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mapSplit,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [31:0]       cpuAddr,
  input  logic [1:0]        cpuSize,
  input  logic [31:0]       cpuWdata,
  output logic [31:0]       cpuRdata,
  output logic              cpuDone,
  output logic              ioRd,
  output logic              ioWr,
  output logic [PORT_W-1:0] ioPort,
  output logic [1:0]        ioSize,
  output logic [31:0]       ioWdata,
  input  logic [31:0]       ioRdata,
  input  logic              ioRvalid,
  input  logic [7:0]        iackVec,
  output logic              iackStb
);

  decode_t  dec;
  ctrlStb_t stb;

  isa_xlate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .cpuWe    (cpuWe),
    .dec      (dec),
    .ioRvalid (ioRvalid),
    .stb      (stb),
    .ioRd     (ioRd),
    .ioWr     (ioWr),
    .iackStb  (iackStb),
    .cpuDone  (cpuDone)
  );

  isa_xlate_dp #(.PORT_W(PORT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .mapSplit (mapSplit),
    .cpuWe    (cpuWe),
    .cpuAddr  (cpuAddr),
    .cpuSize  (cpuSize),
    .cpuWdata (cpuWdata),
    .ioRdata  (ioRdata),
    .iackVec  (iackVec),
    .stb      (stb),
    .dec      (dec),
    .ioPort   (ioPort),
    .ioSize   (ioSize),
    .ioWdata  (ioWdata),
    .cpuRdata (cpuRdata)
  );

endmodule

// File: rtl/isa_window_xlate_chk.sv
module isa_window_xlate_chk
  import isa_xlate_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        cpuReq,
  input logic        cpuWe,
  input logic [31:0] cpuAddr,
  input logic [1:0]  cpuSize,
  input logic [31:0] cpuWdata,
  input logic        cpuDone,
  input logic        ioRd,
  input logic        ioWr,
  input logic [31:0] ioWdata,
  input logic        iackStb
);

  // R2: read and write strobes never coincide
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(ioRd && ioWr));

  // R2: an I/O strobe follows a request inside the window
  a_r2_win_only: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd || ioWr) |-> ($past(cpuReq) && $past(cpuAddr[31:23]) == 9'h100));

  // R5: a forwarded write completes together with its strobe and carries swapped data
  a_r5_write_done: assert property (@(posedge clk) disable iff (!rstN)
    ioWr |-> (cpuDone && ioWdata == laneSwap($past(cpuWdata), $past(cpuSize))));

  // R6: a forwarded read is never completed in its strobe cycle
  a_r6_read_wait: assert property (@(posedge clk) disable iff (!rstN)
    ioRd |-> !cpuDone);

  // R7: acknowledge strobe only after a read of the vector address
  a_r7_iack_src: assert property (@(posedge clk) disable iff (!rstN)
    iackStb |-> ($past(cpuReq) && !$past(cpuWe) && $past(cpuAddr) == 32'hBFFF_FFF0 && cpuDone));

endmodule

bind isa_window_xlate isa_window_xlate_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuReq   (cpuReq),
  .cpuWe    (cpuWe),
  .cpuAddr  (cpuAddr),
  .cpuSize  (cpuSize),
  .cpuWdata (cpuWdata),
  .cpuDone  (cpuDone),
  .ioRd     (ioRd),
  .ioWr     (ioWr),
  .ioWdata  (ioWdata),
  .iackStb  (iackStb)
);

// File: tb/isa_window_xlate_bench.sv
module isa_window_xlate_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mapSplit = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [31:0] cpuAddr = 32'h0;
  logic [1:0]  cpuSize = 2'd0;
  logic [31:0] cpuWdata = 32'h0;
  logic [31:0] cpuRdata;
  logic        cpuDone;
  logic        ioRd;
  logic        ioWr;
  logic [19:0] ioPort;
  logic [1:0]  ioSize;
  logic [31:0] ioWdata;
  logic [31:0] ioRdata = 32'h0;
  logic        ioRvalid = 1'b0;
  logic [7:0]  iackVec = 8'h0;
  logic        iackStb;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  isa_window_xlate u_isa_window_xlate (
    .clk(clk), .rstN(rstN), .mapSplit(mapSplit), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuSize(cpuSize), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuDone(cpuDone), .ioRd(ioRd), .ioWr(ioWr), .ioPort(ioPort), .ioSize(ioSize),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .ioRvalid(ioRvalid), .iackVec(iackVec),
    .iackStb(iackStb)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] expSwap(input logic [31:0] d, input logic [1:0] sz);
    if (sz == 2'd0) return d;
    if (sz == 2'd1) return {16'h0, d[7:0], d[15:8]};
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic [19:0] expPort(input logic [31:0] a, input logic split);
    if (split) return {a[26:12], a[4:0]};
    return {4'h0, a[15:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One CPU access; lat = device delay for forwarded reads.
  task automatic access(input logic we, input logic [31:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, input int lat, input logic [31:0] rd,
                        input logic flipMode, input logic poke);
    logic inWin, inIack, isVec, modeUsed;
    logic [19:0] port;
    inWin  = addr[31:23] == 9'h100;
    inIack = addr[31:2] == 30'h2FFF_FFFC;
    isVec  = addr == 32'hBFFF_FFF0;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuSize = sz; cpuWdata = wd;
    modeUsed = mapSplit;
    port = expPort(addr, modeUsed);
    @(negedge clk);
    cpuReq = 1'b0;
    if (inWin) begin
      check("R2 write strobe", {31'h0, ioWr}, {31'h0, we});
      check("R2 read strobe", {31'h0, ioRd}, {31'h0, !we});
      check("R2 size", {30'h0, ioSize}, {30'h0, sz});
      check(modeUsed ? "R4 split port" : "R3 flat port", {12'h0, ioPort}, {12'h0, port});
      if (we) begin
        check("R5 write data", ioWdata, expSwap(wd, sz));
        check("R5 write done", {31'h0, cpuDone}, 32'h1);
      end else begin
        check("R6 no early done", {31'h0, cpuDone}, 32'h0);
        if (flipMode) mapSplit = !mapSplit;
        if (poke) begin
          cpuReq = 1'b1; cpuWe = 1'b1; cpuAddr = 32'h8000_0040; cpuSize = 2'd0;
          @(negedge clk);
          cpuReq = 1'b0;
          check("R11 ignored request strobe", {30'h0, ioWr, ioRd}, 32'h0);
          check("R11 ignored request done", {31'h0, cpuDone}, 32'h0);
        end
        for (int i = 0; i < lat; i++) @(negedge clk);
        check("R10 port held", {12'h0, ioPort}, {12'h0, port});
        ioRvalid = 1'b1; ioRdata = rd;
        @(negedge clk);
        ioRvalid = 1'b0;
        check("R6 read done", {31'h0, cpuDone}, 32'h1);
        check("R6 read data", cpuRdata, expSwap(rd, sz));
        if (poke) begin
          @(negedge clk);
          check("R11 no late strobe", {30'h0, ioWr, cpuDone}, 32'h0);
        end
      end
    end else if (inIack) begin
      check("R8 no io strobe in ack region", {30'h0, ioWr, ioRd}, 32'h0);
      check("R7 ack done", {31'h0, cpuDone}, 32'h1);
      check(isVec ? "R7 ack strobe" : "R8 ack strobe", {31'h0, iackStb}, {31'h0, isVec && !we});
      if (!we) check(isVec ? "R7 vector" : "R8 zero read", cpuRdata,
                     isVec ? expSwap({24'h0, iackVec}, sz) : 32'h0);
    end else begin
      check("R9 no strobe", {29'h0, ioWr, ioRd, iackStb}, 32'h0);
      check("R9 done", {31'h0, cpuDone}, 32'h1);
      if (!we) check("R9 zero read", cpuRdata, 32'h0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset strobes", {28'h0, ioRd, ioWr, iackStb, cpuDone}, 32'h0);
    check("R1 reset rdata", cpuRdata, 32'h0);

    // Directed corner cases
    mapSplit = 1'b0;
    access(1'b1, 32'h8000_1234, 2'd2, 32'h1122_3344, 0, 0, 1'b0, 1'b0);
    access(1'b1, 32'h807F_FFFE, 2'd1, 32'hAAAA_5A6B, 0, 0, 1'b0, 1'b0);
    access(1'b0, 32'h8000_03F8, 2'd0, 0, 2, 32'hDEAD_BE7F, 1'b0, 1'b0);
    mapSplit = 1'b1;
    access(1'b0, 32'h8123_4567, 2'd2, 0, 1, 32'h0102_0304, 1'b0, 1'b0);
    access(1'b1, 32'h807F_F01F, 2'd0, 32'h0000_00C3, 0, 0, 1'b0, 1'b0);
    access(1'b0, 32'h8040_2013, 2'd1, 0, 3, 32'h0000_BEEF, 1'b1, 1'b0);
    access(1'b0, 32'h8000_0060, 2'd2, 0, 4, 32'hCAFE_F00D, 1'b0, 1'b1);
    iackVec = 8'h5C;
    access(1'b0, 32'hBFFF_FFF0, 2'd0, 0, 0, 0, 1'b0, 1'b0);
    access(1'b0, 32'hBFFF_FFF0, 2'd1, 0, 0, 0, 1'b0, 1'b0);
    access(1'b0, 32'hBFFF_FFF0, 2'd2, 0, 0, 0, 1'b0, 1'b0);
    access(1'b0, 32'hBFFF_FFF2, 2'd0, 0, 0, 0, 1'b0, 1'b0);
    access(1'b1, 32'hBFFF_FFF0, 2'd2, 32'h1234_5678, 0, 0, 1'b0, 1'b0);
    access(1'b0, 32'h8080_0000, 2'd2, 0, 0, 0, 1'b0, 1'b0);
    access(1'b1, 32'h7FFF_FFFC, 2'd2, 32'h0F0F_0F0F, 0, 0, 1'b0, 1'b0);

    // Random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      int kind;
      kind = $urandom_range(0, 5);
      if (kind < 3) a = {9'h100, 23'($urandom)};
      else if (kind == 3) a = {30'h2FFF_FFFC, 2'($urandom)};
      else a = $urandom & 32'h7FFF_FFFF;
      mapSplit = 1'($urandom);
      iackVec = 8'($urandom);
      access(1'($urandom), a, 2'($urandom_range(0, 2)), $urandom,
             $urandom_range(0, 4), $urandom, 1'($urandom), 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule